// File: doc/BRIEF.md
# Raster slot and line counter

This block produces the raster position of a tile-based video display processor. An 8-bit horizontal slot counter moves forward once for every access slot, and a 9-bit vertical line counter moves forward once per line. Neither counter runs through its full range in order. The horizontal count skips a gap in the narrow layouts. The vertical count jumps from the end of the frame into high values before it wraps to zero. The line count changes partway through the horizontal count, at a slot that depends on the display mode.

A slot-enable strobe from the clock divider advances the block. Three more inputs choose the display mode: legacy or native, 32- or 40-cell width, and NTSC or PAL with 28 or 30 rows. The mode is sampled only on the line-change step, so the thresholds never change in the middle of a line. The block drives four outputs. It exposes the two counters, pulses a line-advance strobe, keeps a vertical-blank flag, and pulses a vertical-interrupt strobe on the interrupt slot of the first inactive line.

Top module: `vdp_raster_counter`

## Requirements
- R1: While rst_n is low, hslot and vcount are 0 and line_adv, vblank and vint are 0. The latched mode is native, 32-cell, NTSC, 28-row.
- R2: hslot changes only on a clock edge where slot_en is 1. Each such edge moves it to the next slot of the sequence. With slot_en at 0, hslot, vcount and vblank hold.
- R3: In legacy mode (latched legacy_mode=1) and in native 32-cell (wide_mode=0), hslot runs 0..147, then 233..255, then wraps to 0. In native 40-cell (wide_mode=1), hslot runs 0..255 and wraps to 0.
- R4: vcount changes only on an enabled step that leaves the line-change slot. That slot is 249 in legacy mode, 132 in native 32-cell and 165 in native 40-cell. line_adv is 1 for exactly the one cycle in which the new vcount first shows.
- R5: On a line change, vcount follows one of these rules. Legacy: 0xDB becomes 0x1D5. Native NTSC (pal_mode=0): 0xEB becomes 0x1E5. Native PAL, 28 rows (tall_mode=0): 0x103 becomes 0x1CA. Native PAL, 30 rows (tall_mode=1): 0x10B becomes 0x1D2. Any other value goes up by one, and 0x1FF wraps to 0.
- R6: The four mode inputs are latched only on the line-change step. The decisions taken on that step use the values latched before it. wide_mode has no effect in legacy mode. tall_mode matters only in native PAL.
- R7: The active line count is 192 in legacy mode, 240 in native PAL with 30 rows, and 224 otherwise. vblank is 1 when vcount is at or above that count. In legacy mode vblank is updated in the same cycle as vcount. In native mode it is updated in the cycle in which hslot first shows the line-change slot plus 2.
- R8: vint is 1 for one cycle, the cycle in which hslot first shows the interrupt slot while vcount equals the active line count. The interrupt slot is 4 in legacy mode and 255 in native mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_en | input | 1 | Advance by one access slot on this edge |
| legacy_mode | input | 1 | 1 selects the legacy display mode, 0 the native one |
| wide_mode | input | 1 | 1 selects 40-cell width, 0 selects 32-cell (native only) |
| pal_mode | input | 1 | 1 selects PAL line timing, 0 selects NTSC (native only) |
| tall_mode | input | 1 | 1 selects 30 rows, 0 selects 28 rows (native PAL only) |
| hslot | output | 8 | Horizontal slot count |
| vcount | output | 9 | Vertical line count |
| line_adv | output | 1 | One-cycle strobe with each new line value |
| vblank | output | 1 | Vertical blanking flag |
| vint | output | 1 | One-cycle vertical interrupt strobe |

## Verification
Every output is a register. A step taken on the rising edge where slot_en is 1 is therefore visible on hslot, vcount, line_adv, vblank and vint from that edge until the next one. The one exception is the native vblank update, which is due two enabled steps after the line change. The bench drives the inputs at the falling edge and advances its own model once for each edge. It compares all five outputs at the next falling edge, so each result is checked exactly one edge after the stimulus that caused it. Mode changes are applied at arbitrary slots, which checks that the block latches them only on the line-change step.

// File: rtl/vdp_raster_counter.sv
module vdp_raster_counter #(
  parameter int H_W = 8,
  parameter int V_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_en,
  input  logic           legacy_mode,
  input  logic           wide_mode,
  input  logic           pal_mode,
  input  logic           tall_mode,
  output logic [H_W-1:0] hslot,
  output logic [V_W-1:0] vcount,
  output logic           line_adv,
  output logic           vblank,
  output logic           vint
);
  localparam logic [H_W-1:0] GAP_FROM = H_W'(147);
  localparam logic [H_W-1:0] GAP_TO   = H_W'(233);
  localparam logic [H_W-1:0] CHG_LEG  = H_W'(249);
  localparam logic [H_W-1:0] CHG_N32  = H_W'(132);
  localparam logic [H_W-1:0] CHG_N40  = H_W'(165);
  localparam logic [H_W-1:0] VI_LEG   = H_W'(4);
  localparam logic [H_W-1:0] VI_NAT   = H_W'(255);
  localparam logic [V_W-1:0] ACT_LEG  = V_W'(192);
  localparam logic [V_W-1:0] ACT_28   = V_W'(224);
  localparam logic [V_W-1:0] ACT_30   = V_W'(240);
  localparam logic [V_W-1:0] DEST_MIN = V_W'(9'h1CA);
  localparam logic [V_W-1:0] SRC_MIN  = V_W'(9'h0DB);

  logic           leg_q, w40_q, pal_q, tall_q;
  logic           narrow, at_chg, nat_vb_upd;
  logic [H_W-1:0] chg_slot, vi_slot, h_nxt;
  logic [V_W-1:0] act_lines, jmp_from, jmp_to, v_nxt;

  assign narrow    = leg_q | ~w40_q;
  assign chg_slot  = leg_q ? CHG_LEG : (w40_q ? CHG_N40 : CHG_N32);
  assign vi_slot   = leg_q ? VI_LEG : VI_NAT;
  assign act_lines = leg_q ? ACT_LEG : ((pal_q & tall_q) ? ACT_30 : ACT_28);

  always_comb begin
    if (leg_q) begin
      jmp_from = V_W'(9'h0DB); jmp_to = V_W'(9'h1D5);
    end else if (!pal_q) begin
      jmp_from = V_W'(9'h0EB); jmp_to = V_W'(9'h1E5);
    end else if (tall_q) begin
      jmp_from = V_W'(9'h10B); jmp_to = V_W'(9'h1D2);
    end else begin
      jmp_from = V_W'(9'h103); jmp_to = V_W'(9'h1CA);
    end
  end

  assign h_nxt      = (narrow && hslot == GAP_FROM) ? GAP_TO : hslot + H_W'(1);
  assign v_nxt      = (vcount == jmp_from) ? jmp_to : vcount + V_W'(1);
  assign at_chg     = slot_en && hslot == chg_slot;
  assign nat_vb_upd = slot_en && !leg_q && hslot == chg_slot + H_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hslot    <= '0;
      vcount   <= '0;
      line_adv <= 1'b0;
      vblank   <= 1'b0;
      vint     <= 1'b0;
      leg_q    <= 1'b0;
      w40_q    <= 1'b0;
      pal_q    <= 1'b0;
      tall_q   <= 1'b0;
    end else begin
      line_adv <= at_chg;
      vint     <= slot_en && !at_chg && h_nxt == vi_slot && vcount == act_lines;
      if (slot_en) hslot <= h_nxt;
      if (at_chg) begin
        vcount <= v_nxt;
        leg_q  <= legacy_mode;
        w40_q  <= wide_mode;
        pal_q  <= pal_mode;
        tall_q <= tall_mode;
        if (leg_q) vblank <= (v_nxt >= act_lines);
      end else if (nat_vb_upd) begin
        vblank <= (vcount >= act_lines);
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(hslot) && $stable(vcount));

  assert_gap_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en && hslot == GAP_FROM && (leg_q || !w40_q) |=> hslot == GAP_TO);

  assert_line_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcount) |-> line_adv);

  assert_line_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv |=> !line_adv);

  assert_vstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv |-> (vcount == $past(vcount) + V_W'(1)) ||
                 ($past(vcount) >= SRC_MIN && vcount >= DEST_MIN));

  assert_vb_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vblank) |-> $past(slot_en));

  assert_vint_in_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vint |-> vblank);

  assert_vint_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vint |=> !vint);
endmodule

// File: tb/sim_vdp_raster_counter.sv
module sim_vdp_raster_counter;
  logic clk = 1'b0, rst_n = 1'b0, slot_en = 1'b0;
  logic legacy_mode = 1'b0, wide_mode = 1'b0, pal_mode = 1'b0, tall_mode = 1'b0;
  logic [7:0] hslot;
  logic [8:0] vcount;
  logic line_adv, vblank, vint;

  always #4 clk = ~clk;

  vdp_raster_counter u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
    .legacy_mode(legacy_mode), .wide_mode(wide_mode),
    .pal_mode(pal_mode), .tall_mode(tall_mode),
    .hslot(hslot), .vcount(vcount), .line_adv(line_adv),
    .vblank(vblank), .vint(vint)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  int e_h, e_v;
  bit e_line, e_vb, e_vint;
  bit m_leg, m_w40, m_pal, m_tall;
  string h_tag, v_tag;
  bit seen_leg, seen_ntsc, seen_p28, seen_p30;
  int dut_vints, exp_vints;

  function automatic int change_slot(bit lg, bit w);
    if (lg) return 249;
    return w ? 165 : 132;
  endfunction

  function automatic int lines_active(bit lg, bit p, bit t);
    if (lg) return 192;
    return (p && t) ? 240 : 224;
  endfunction

  function automatic int follow_line(int v, bit lg, bit p, bit t);
    if (lg && v == 219) return 469;
    if (!lg && !p && v == 235) return 485;
    if (!lg && p && !t && v == 259) return 458;
    if (!lg && p && t && v == 267) return 466;
    return (v + 1) % 512;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic model_reset();
    e_h = 0; e_v = 0; e_line = 0; e_vb = 0; e_vint = 0;
    m_leg = 0; m_w40 = 0; m_pal = 0; m_tall = 0;
    h_tag = "R1"; v_tag = "R1";
  endtask

  task automatic step_model(bit en);
    bit narrow, pend;
    int cs, act, hn, nv;
    narrow = m_leg || !m_w40;
    cs = change_slot(m_leg, m_w40);
    act = lines_active(m_leg, m_pal, m_tall);
    pend = (m_leg != legacy_mode) || (m_w40 != wide_mode) ||
           (m_pal != pal_mode) || (m_tall != tall_mode);
    e_line = 0; e_vint = 0;
    h_tag = pend ? "R6" : "R2";
    v_tag = pend ? "R6" : "R4";
    if (en) begin
      hn = (narrow && e_h == 147) ? 233 : (e_h + 1) % 256;
      if ((narrow && e_h == 147) || e_h == 255) h_tag = "R3";
      e_vint = (hn == (m_leg ? 4 : 255)) && (e_v == act) && (e_h != cs);
      if (e_h == cs) begin
        nv = follow_line(e_v, m_leg, m_pal, m_tall);
        if (nv != (e_v + 1) % 512) begin
          v_tag = "R5";
          if (m_leg) seen_leg = 1;
          else if (!m_pal) seen_ntsc = 1;
          else if (m_tall) seen_p30 = 1;
          else seen_p28 = 1;
        end
        e_line = 1;
        if (m_leg) e_vb = (nv >= act);
        m_leg = legacy_mode; m_w40 = wide_mode; m_pal = pal_mode; m_tall = tall_mode;
        e_v = nv;
      end else if (!m_leg && e_h == (cs + 1) % 256) begin
        e_vb = (e_v >= act);
      end
      e_h = hn;
    end
  endtask

  task automatic compare_all();
    check(h_tag, "hslot", int'(hslot), e_h);
    check(v_tag, "vcount", int'(vcount), e_v);
    check("R4", "line_adv", int'(line_adv), int'(e_line));
    check("R7", "vblank", int'(vblank), int'(e_vb));
    check("R8", "vint", int'(vint), int'(e_vint));
    if (vint) dut_vints++;
    if (e_vint) exp_vints++;
  endtask

  task automatic one_cycle(bit en);
    slot_en = en;
    step_model(en);
    @(negedge clk);
    compare_all();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; slot_en = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    check("R1", "reset hslot", int'(hslot), 0);
    check("R1", "reset vcount", int'(vcount), 0);
    check("R1", "reset line_adv", int'(line_adv), 0);
    check("R1", "reset vblank", int'(vblank), 0);
    check("R1", "reset vint", int'(vint), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 199000 && !done) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 watchdog: actual %0d cycles expected below 199000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7715));
    @(negedge clk);
    apply_reset();
    // random phase: gated slots and mode toggles at arbitrary slots
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 49) == 0) legacy_mode = ~legacy_mode;
      if ($urandom_range(0, 49) == 0) wide_mode = ~wide_mode;
      if ($urandom_range(0, 49) == 0) pal_mode = ~pal_mode;
      if ($urandom_range(0, 49) == 0) tall_mode = ~tall_mode;
      one_cycle($urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < 40; i++) one_cycle(1'b0);
    legacy_mode = 1'b1;
    apply_reset();
    seen_leg = 0; seen_ntsc = 0; seen_p28 = 0; seen_p30 = 0;
    dut_vints = 0; exp_vints = 0;
    // legacy frame with width and region toggled (both ignored here)
    while (!(seen_leg && e_v == 0)) begin
      wide_mode = 1'($urandom_range(0, 1));
      pal_mode = 1'($urandom_range(0, 1));
      one_cycle(1'b1);
    end
    legacy_mode = 1'b0; wide_mode = 1'b0; pal_mode = 1'b0;
    while (!(seen_ntsc && e_v == 0)) begin
      tall_mode = 1'($urandom_range(0, 1));
      one_cycle(1'b1);
    end
    pal_mode = 1'b1; tall_mode = 1'b0;
    while (!(seen_p28 && e_v == 0)) one_cycle(1'b1);
    tall_mode = 1'b1;
    while (!seen_p30) one_cycle(1'b1);
    for (int i = 0; i < 400; i++) one_cycle(1'b1);
    check("R5", "legacy jump reached", int'(seen_leg), 1);
    check("R5", "NTSC jump reached", int'(seen_ntsc), 1);
    check("R5", "PAL 28-row jump reached", int'(seen_p28), 1);
    check("R5", "PAL 30-row jump reached", int'(seen_p30), 1);
    check("R8", "vint pulse count", dut_vints, exp_vints);
    check("R8", "expected vint pulses", exp_vints, 4);
    summary();
    $finish;
  end
endmodule